// File: doc/BRIEF.md
# In-Band Interrupt Event Handler

This block sits inside a serial-bus controller and services in-band interrupt requests. A bus engine wins arbitration on behalf of a requester and hands the block the requester's 7-bit address and its direction bit over a valid/ready event interface. The block sorts the request into one of three kinds: a new device asking to join, a secondary controller asking to take over the bus, or a target raising an interrupt. It then decides whether to acknowledge the request and reports that decision back to the engine with a single-cycle pulse.

An acknowledged target interrupt may carry payload bytes. The block stores them up to a programmable limit. Every accepted request sets a sticky pending bit for its kind, and those bits drive an interrupt line to software. When the engine signals that servicing is over, the block publishes one record to a software-readable queue. The record is a status word followed by the captured payload bytes. Space for the whole record is set aside before the request is acknowledged. The bytes are written ahead of time but stay hidden until the status word is committed, so a reader never sees part of a record.

Top module: `ibi_handler`

## Requirements
- R1: A request is classified as follows. Address 7'h02 written is a join request (kind code 0). A write from an address held in an enabled address-table entry is a controller-role request (kind code 1). Any read is a target interrupt (kind code 2). Any other write is unrecognised (kind code 3).
- R2: A join request is acknowledged only while `hj_ack_en` is 1. A controller-role request is acknowledged only while `crr_ack_en` is 1. Both also need room in the queue.
- R3: A target interrupt is acknowledged only when its address matches an enabled table entry and the queue has room. A request from an unknown address is not acknowledged but still gets a status record. An unrecognised write is never acknowledged.
- R4: Accepting a request sets bit `kind` of `irq_pend`, visible one cycle after acceptance. `irq` is the OR of the pending bits. Each bit of `irq_clr` clears the matching pending bit, and a new set takes priority over a clear in the same cycle.
- R5: No part of a record becomes visible on the queue read port until the cycle after `svc_done` has been seen. The record is committed two clock edges after `svc_done`.
- R6: The status entry is 20 bits. Bit 19 is 1 (status tag), bit 18 is overflow, bits 17:10 are the stored byte count, bit 9 is ack, bits 8:2 are the address, and bits 1:0 are the kind. Payload entries have bit 19 at 0 and the byte in bits 7:0.
- R7: The payload bytes of an acknowledged target interrupt follow their status entry in arrival order, and the count equals the number of bytes stored.
- R8: Only the first `max_bytes` bytes are stored. When any further bytes arrive, those bytes are dropped and the overflow bit is set.
- R9: A request is acknowledged only if the free space is at least 1 entry (hot-join/role request) or 1+`max_bytes` entries (target interrupt). A refused request still logs a status entry when at least one entry is free. When the queue is full, nothing is written.
- R10: Payload bytes offered during a request that was not acknowledged are ignored and do not appear in the queue.
- R11: `evt_ready` is high only when the block is idle. `dec_valid` pulses for exactly one cycle, in the cycle after the request is accepted, and `dec_ack` carries the decision during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Bus engine offers a request |
| evt_ready | output | 1 | Block is idle and takes the request |
| evt_addr | input | 7 | Requester address |
| evt_rnw | input | 1 | Direction bit, 1 = read |
| dec_valid | output | 1 | Decision pulse |
| dec_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| pl_valid | input | 1 | Payload byte strobe |
| pl_data | input | 8 | Payload byte |
| svc_done | input | 1 | Servicing of the current request has ended |
| dev_addr | input | NDEV*7 | Known dynamic addresses, entry i in bits 7i+6:7i |
| dev_en | input | NDEV | Enable per address-table entry |
| hj_ack_en | input | 1 | Acknowledge join requests |
| crr_ack_en | input | 1 | Acknowledge controller-role requests |
| max_bytes | input | LW | Payload byte limit |
| irq_clr | input | 4 | Clear mask for pending bits |
| irq | output | 1 | Interrupt to software |
| irq_pend | output | 4 | Pending bit per kind |
| q_rd | input | 1 | Pop the queue head |
| q_data | output | 20 | Queue head entry |
| q_empty | output | 1 | No committed entry is available |

## Verification
The assertions assume the bus engine follows the protocol. It raises `pl_valid` and `svc_done` only after the decision pulse has been given. It raises `svc_done` once per request. It changes the request fields only while `evt_valid` is high and idle. The bench drives every input on the falling edge, following that sequence. It raises `evt_valid` for one cycle while `evt_ready` is high, sends any bytes after the decision pulse, and only then asserts `svc_done`. It pops the queue only between requests. The tests that fill the queue are built so that the free-space arithmetic reaches exactly zero.

// File: rtl/ibi_pkg.sv
package ibi_pkg;

    localparam logic [6:0] JOIN_ADDR = 7'h02;
    localparam int ENTRY_W = 20;

    typedef enum logic [1:0] {
        KIND_JOIN  = 2'd0,
        KIND_ROLE  = 2'd1,
        KIND_TIRQ  = 2'd2,
        KIND_OTHER = 2'd3
    } ibi_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_SERVE,
        ST_COMMIT
    } ibi_state_e;

    typedef struct packed {
        logic       tag;
        logic       ovf;
        logic [7:0] cnt;
        logic       ack;
        logic [6:0] addr;
        ibi_kind_e  kind;
    } ibi_status_t;

endpackage

// File: rtl/ibi_classify.sv
module ibi_classify
    import ibi_pkg::*;
#(
    parameter int NDEV = 4
) (
    input  logic [6:0]        addr,
    input  logic              rnw,
    input  logic [NDEV*7-1:0] dev_addr,
    input  logic [NDEV-1:0]   dev_en,
    input  logic              hj_ack_en,
    input  logic              crr_ack_en,
    output ibi_kind_e         kind,
    output logic              allowed
);
    logic [NDEV-1:0] hit;
    logic            known;

    for (genvar i = 0; i < NDEV; i++) begin : g_match
        assign hit[i] = dev_en[i] && (dev_addr[i*7 +: 7] == addr);
    end

    assign known = |hit;

    always_comb begin
        if (rnw)                    kind = KIND_TIRQ;
        else if (addr == JOIN_ADDR) kind = KIND_JOIN;
        else if (known)             kind = KIND_ROLE;
        else                        kind = KIND_OTHER;

        unique case (kind)
            KIND_JOIN: allowed = hj_ack_en;
            KIND_ROLE: allowed = crr_ack_en;
            KIND_TIRQ: allowed = known;
            default:   allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/ibi_queue.sv
module ibi_queue #(
    parameter int DEPTH = 32,
    parameter int W     = 20,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_off,
    input  logic [W-1:0]  wr_data,
    input  logic          commit_en,
    input  logic [AW:0]   commit_len,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic          empty,
    output logic [AW:0]   free
);
    typedef struct packed {
        logic [AW:0] wptr;
        logic [AW:0] rptr;
    } qptr_t;

    qptr_t        p_q, p_d;
    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  used;

    assign used    = p_q.wptr - p_q.rptr;
    assign free    = (AW+1)'(DEPTH) - used;
    assign empty   = (used == '0);
    assign rd_data = mem[p_q.rptr[AW-1:0]];

    always_comb begin
        p_d = p_q;
        if (commit_en)       p_d.wptr = p_q.wptr + commit_len;
        if (rd_en && !empty) p_d.rptr = p_q.rptr + (AW+1)'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[p_q.wptr[AW-1:0] + wr_off] <= wr_data;
    end
endmodule

// File: rtl/ibi_handler.sv
module ibi_handler
    import ibi_pkg::*;
#(
    parameter int NDEV  = 4,
    parameter int DEPTH = 32,
    parameter int LW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [6:0]        evt_addr,
    input  logic              evt_rnw,
    output logic              dec_valid,
    output logic              dec_ack,
    input  logic              pl_valid,
    input  logic [7:0]        pl_data,
    input  logic              svc_done,
    input  logic [NDEV*7-1:0] dev_addr,
    input  logic [NDEV-1:0]   dev_en,
    input  logic              hj_ack_en,
    input  logic              crr_ack_en,
    input  logic [LW-1:0]     max_bytes,
    input  logic [3:0]        irq_clr,
    output logic              irq,
    output logic [3:0]        irq_pend,
    input  logic              q_rd,
    output logic [19:0]       q_data,
    output logic              q_empty
);
    typedef struct packed {
        ibi_state_e st;
        ibi_kind_e  kind;
        logic [6:0] addr;
        logic       ack;
        logic       log;
        logic [7:0] cnt;
        logic       ovf;
        logic [3:0] pend;
    } hreg_t;

    hreg_t r_q, r_d;

    ibi_kind_e          cls_kind;
    logic               cls_allowed;
    logic [AW:0]        q_free;
    logic [AW:0]        need;
    logic               wr_en;
    logic [AW-1:0]      wr_off;
    logic [ENTRY_W-1:0] wr_data;
    logic               commit_en;
    logic [AW:0]        commit_len;
    logic [3:0]         set_vec;
    ibi_status_t        stat;

    logic               serving_w;
    logic               q_full_w;

    ibi_classify #(.NDEV(NDEV)) u_cls (
        .addr       (evt_addr),
        .rnw        (evt_rnw),
        .dev_addr   (dev_addr),
        .dev_en     (dev_en),
        .hj_ack_en  (hj_ack_en),
        .crr_ack_en (crr_ack_en),
        .kind       (cls_kind),
        .allowed    (cls_allowed)
    );

    ibi_queue #(.DEPTH(DEPTH), .W(ENTRY_W)) u_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_off     (wr_off),
        .wr_data    (wr_data),
        .commit_en  (commit_en),
        .commit_len (commit_len),
        .rd_en      (q_rd),
        .rd_data    (q_data),
        .empty      (q_empty),
        .free       (q_free)
    );

    assign need = (AW+1)'(1) + ((cls_kind == KIND_TIRQ) ? (AW+1)'(max_bytes) : '0);

    always_comb begin
        stat      = '{tag: 1'b1, ovf: r_q.ovf, cnt: r_q.cnt, ack: r_q.ack,
                      addr: r_q.addr, kind: r_q.kind};
        r_d       = r_q;
        set_vec   = '0;
        wr_en     = 1'b0;
        wr_off    = '0;
        wr_data   = '0;
        commit_en = 1'b0;
        commit_len = '0;
        evt_ready = 1'b0;
        dec_valid = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                evt_ready = 1'b1;
                if (evt_valid) begin
                    r_d.st     = ST_DECIDE;
                    r_d.kind   = cls_kind;
                    r_d.addr   = evt_addr;
                    r_d.ack    = cls_allowed && (q_free >= need);
                    r_d.log    = (q_free != '0);
                    r_d.cnt    = '0;
                    r_d.ovf    = 1'b0;
                    set_vec[cls_kind] = 1'b1;
                end
            end
            ST_DECIDE: begin
                dec_valid = 1'b1;
                r_d.st    = ST_SERVE;
            end
            ST_SERVE: begin
                if (pl_valid && r_q.ack && (r_q.kind == KIND_TIRQ)) begin
                    if (r_q.cnt < 8'(max_bytes)) begin
                        wr_en   = 1'b1;
                        wr_off  = AW'(r_q.cnt) + AW'(1);
                        wr_data = {12'h000, pl_data};
                        r_d.cnt = r_q.cnt + 8'd1;
                    end else begin
                        r_d.ovf = 1'b1;
                    end
                end
                if (svc_done) r_d.st = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (r_q.log) begin
                    wr_en      = 1'b1;
                    wr_off     = '0;
                    wr_data    = stat;
                    commit_en  = 1'b1;
                    commit_len = (AW+1)'(r_q.cnt) + (AW+1)'(1);
                end
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        r_d.pend = (r_q.pend & ~irq_clr) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, kind: KIND_JOIN, default: '0};
        else        r_q <= r_d;
    end

    assign dec_ack   = r_q.ack;
    assign irq_pend  = r_q.pend;
    assign irq       = |r_q.pend;
    assign serving_w = (r_q.st == ST_SERVE);
    assign q_full_w  = (q_free == '0);
endmodule

// File: rtl/ibi_handler_chk.sv
module ibi_handler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_valid,
    input logic       evt_ready,
    input logic       dec_valid,
    input logic       dec_ack,
    input logic       irq,
    input logic [3:0] irq_clr,
    input logic       q_empty,
    input logic       serving,
    input logic       q_full
);
    // R11
    dec_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready) |=> dec_valid);

    // R11
    dec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !evt_ready);

    // R4
    irq_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && (irq_clr == 4'h0)) |=> irq);

    // R5
    no_early_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && q_empty) |=> q_empty);

    // R9
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && q_full) |=> !dec_ack);
endmodule

bind ibi_handler ibi_handler_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .dec_valid (dec_valid),
    .dec_ack   (dec_ack),
    .irq       (irq),
    .irq_clr   (irq_clr),
    .q_empty   (q_empty),
    .serving   (serving_w),
    .q_full    (q_full_w)
);

// File: tb/sim_ibi_handler.sv
`timescale 1ns/1ps
module sim_ibi_handler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [6:0]  evt_addr = '0;
    logic        evt_rnw = 1'b0;
    logic        dec_valid, dec_ack;
    logic        pl_valid = 1'b0;
    logic [7:0]  pl_data = '0;
    logic        svc_done = 1'b0;
    logic [27:0] dev_addr = {7'h33, 7'h22, 7'h11, 7'h0A};
    logic [3:0]  dev_en = 4'b0111;
    logic        hj_ack_en = 1'b1;
    logic        crr_ack_en = 1'b1;
    logic [3:0]  max_bytes = 4'd8;
    logic [3:0]  irq_clr = '0;
    logic        irq;
    logic [3:0]  irq_pend;
    logic        q_rd = 1'b0;
    logic [19:0] q_data;
    logic        q_empty;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ibi_handler u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_addr(evt_addr), .evt_rnw(evt_rnw), .dec_valid(dec_valid), .dec_ack(dec_ack),
        .pl_valid(pl_valid), .pl_data(pl_data), .svc_done(svc_done),
        .dev_addr(dev_addr), .dev_en(dev_en), .hj_ack_en(hj_ack_en),
        .crr_ack_en(crr_ack_en), .max_bytes(max_bytes), .irq_clr(irq_clr),
        .irq(irq), .irq_pend(irq_pend), .q_rd(q_rd), .q_data(q_data), .q_empty(q_empty)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] st_word(input logic [1:0] k, input logic [6:0] a,
                                            input logic ack, input logic [7:0] n, input logic ovf);
        return {1'b1, ovf, n, ack, a, k};
    endfunction

    // Runs one request; returns the decision seen on dec_ack.
    task automatic run_event(input logic [6:0] a, input logic rnw, input int nb,
                             input logic [7:0] seed, input bit expect_empty, output bit ack);
        @(negedge clk);
        chk(evt_ready, "R11 ready when idle", {31'b0, evt_ready}, 1);
        evt_addr = a; evt_rnw = rnw; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        chk(dec_valid && !evt_ready, "R11 decision pulse", {30'b0, dec_valid, evt_ready}, 32'h2);
        ack = dec_ack;
        @(negedge clk);
        chk(!dec_valid, "R11 pulse one cycle", {31'b0, dec_valid}, 0);
        for (int i = 0; i < nb; i++) begin
            pl_data = seed + 8'(i); pl_valid = 1'b1;
            @(negedge clk);
        end
        pl_valid = 1'b0;
        if (expect_empty) chk(q_empty, "R5 hidden before done", {31'b0, q_empty}, 1);
        svc_done = 1'b1;
        @(negedge clk);
        svc_done = 1'b0;
        if (expect_empty) chk(q_empty, "R5 hidden until commit", {31'b0, q_empty}, 1);
        @(negedge clk);
    endtask

    task automatic pop_check(input logic [19:0] exp, input string req);
        chk(!q_empty && q_data == exp, req, {11'b0, q_empty, q_data}, {12'b0, exp});
        q_rd = 1'b1;
        @(negedge clk);
        q_rd = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 4'hF;
        @(negedge clk);
        irq_clr = 4'h0;
    endtask

    task automatic t_reset();
        chk(evt_ready, "R11 reset ready", {31'b0, evt_ready}, 1);
        chk(!irq && irq_pend == 0, "R4 reset irq", {27'b0, irq, irq_pend}, 0);
        chk(q_empty, "R5 reset queue empty", {31'b0, q_empty}, 1);
    endtask

    task automatic t_join();
        bit ack;
        hj_ack_en = 1'b1;
        run_event(7'h02, 1'b0, 0, 8'h00, 1, ack);
        chk(ack, "R2 join acked when enabled", {31'b0, ack}, 1);
        chk(irq && irq_pend == 4'b0001, "R4 join pending bit", {27'b0, irq, irq_pend}, 32'h11);
        pop_check(st_word(2'd0, 7'h02, 1'b1, 8'd0, 1'b0), "R1 R6 join status");
        hj_ack_en = 1'b0;
        run_event(7'h02, 1'b0, 0, 8'h00, 1, ack);
        chk(!ack, "R2 join refused when disabled", {31'b0, ack}, 0);
        pop_check(st_word(2'd0, 7'h02, 1'b0, 8'd0, 1'b0), "R2 join refusal logged");
        hj_ack_en = 1'b1;
        clear_irq();
    endtask

    task automatic t_role();
        bit ack;
        crr_ack_en = 1'b1;
        run_event(7'h11, 1'b0, 0, 8'h00, 1, ack);
        chk(ack, "R2 role request acked", {31'b0, ack}, 1);
        chk(irq_pend == 4'b0010, "R4 role pending bit", {28'b0, irq_pend}, 32'h2);
        pop_check(st_word(2'd1, 7'h11, 1'b1, 8'd0, 1'b0), "R1 role status");
        crr_ack_en = 1'b0;
        run_event(7'h11, 1'b0, 0, 8'h00, 1, ack);
        chk(!ack, "R2 role request refused", {31'b0, ack}, 0);
        pop_check(st_word(2'd1, 7'h11, 1'b0, 8'd0, 1'b0), "R2 role refusal logged");
        crr_ack_en = 1'b1;
        clear_irq();
    endtask

    task automatic t_target();
        bit ack;
        max_bytes = 4'd8;
        run_event(7'h22, 1'b1, 3, 8'hA0, 1, ack);
        chk(ack, "R3 known target acked", {31'b0, ack}, 1);
        chk(irq_pend == 4'b0100, "R4 target pending bit", {28'b0, irq_pend}, 32'h4);
        pop_check(st_word(2'd2, 7'h22, 1'b1, 8'd3, 1'b0), "R6 target status");
        for (int i = 0; i < 3; i++) pop_check({12'h000, 8'hA0 + 8'(i)}, "R7 payload order");
        chk(q_empty, "R7 record ends after payload", {31'b0, q_empty}, 1);
        clear_irq();
    endtask

    task automatic t_unknown();
        bit ack;
        run_event(7'h33, 1'b1, 2, 8'hC0, 1, ack);
        chk(!ack, "R3 unknown target refused", {31'b0, ack}, 0);
        pop_check(st_word(2'd2, 7'h33, 1'b0, 8'd0, 1'b0), "R3 unknown target logged");
        chk(q_empty, "R10 refused bytes ignored", {31'b0, q_empty}, 1);
        run_event(7'h44, 1'b0, 0, 8'h00, 1, ack);
        chk(!ack, "R3 unrecognised write refused", {31'b0, ack}, 0);
        chk(irq_pend == 4'b1100, "R4 kinds 2 and 3 pending", {28'b0, irq_pend}, 32'hC);
        pop_check(st_word(2'd3, 7'h44, 1'b0, 8'd0, 1'b0), "R1 unrecognised kind");
        clear_irq();
        chk(!irq && irq_pend == 0, "R4 clear mask", {27'b0, irq, irq_pend}, 0);
    endtask

    task automatic t_overflow();
        bit ack;
        max_bytes = 4'd4;
        run_event(7'h0A, 1'b1, 6, 8'h10, 1, ack);
        chk(ack, "R8 target acked", {31'b0, ack}, 1);
        pop_check(st_word(2'd2, 7'h0A, 1'b1, 8'd4, 1'b1), "R8 count capped, overflow set");
        for (int i = 0; i < 4; i++) pop_check({12'h000, 8'h10 + 8'(i)}, "R8 stored bytes");
        chk(q_empty, "R8 excess dropped", {31'b0, q_empty}, 1);
        clear_irq();
    endtask

    task automatic t_room();
        bit ack;
        max_bytes = 4'd15;
        run_event(7'h11, 1'b1, 10, 8'h30, 1, ack);
        chk(ack, "R9 A fits", {31'b0, ack}, 1);
        run_event(7'h22, 1'b1, 10, 8'h50, 0, ack);
        chk(ack, "R9 B fits", {31'b0, ack}, 1);
        run_event(7'h0A, 1'b1, 3, 8'h60, 0, ack);
        chk(!ack, "R9 C refused for room", {31'b0, ack}, 0);
        max_bytes = 4'd8;
        run_event(7'h0A, 1'b1, 8, 8'h70, 0, ack);
        chk(ack, "R9 D fills exactly", {31'b0, ack}, 1);
        run_event(7'h02, 1'b0, 0, 8'h00, 0, ack);
        chk(!ack, "R9 full queue refuses join", {31'b0, ack}, 0);
        pop_check(st_word(2'd2, 7'h11, 1'b1, 8'd10, 1'b0), "R9 A status");
        for (int i = 0; i < 10; i++) pop_check({12'h000, 8'h30 + 8'(i)}, "R7 A payload");
        pop_check(st_word(2'd2, 7'h22, 1'b1, 8'd10, 1'b0), "R9 B status");
        for (int i = 0; i < 10; i++) pop_check({12'h000, 8'h50 + 8'(i)}, "R7 B payload");
        pop_check(st_word(2'd2, 7'h0A, 1'b0, 8'd0, 1'b0), "R9 C logged without payload");
        pop_check(st_word(2'd2, 7'h0A, 1'b1, 8'd8, 1'b0), "R9 D status");
        for (int i = 0; i < 8; i++) pop_check({12'h000, 8'h70 + 8'(i)}, "R7 D payload");
        chk(q_empty, "R9 full-queue request not written", {31'b0, q_empty}, 1);
        clear_irq();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_join();
        t_role();
        t_target();
        t_unknown();
        t_overflow();
        t_room();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule